// File: doc/BRIEF.md
# Character-Synchronous Serial Receiver

This block takes a serial bit stream, one bit per cycle in which `bit_vld` is high, and turns it into characters. Bits arrive least significant bit first. Before any data is delivered, the block must find character alignment. It does this by sliding a window along the stream until the window equals a programmed sync pattern. It then requires a second, aligned copy of the pattern. After that it opens the data path, and every later character is framed at the same boundaries. When stripping is on, sync characters found before or inside the data are dropped.

Each delivered character goes to a data register and raises `data_avail`. Error events go to a status register and raise `stat_avail`. The host takes data and status with one-cycle read strobes. Error control can be set to one of three modes:
- none;
- a CRC-16 accumulator that reports a good remainder for one character;
- per-character parity, even or odd, which is checked and then removed before delivery.

The host decides where a message ends. It drops `rx_en` to reset the receiver and make it hunt again.

Top module: `bsync_rx`

## Requirements
- R1: While reset is asserted, and after it is released, `data_avail`, `stat_avail`, `rx_active`, `rx_data` and `rx_stat` are all zero.
- R2: The data path opens only after two back-to-back aligned characters equal the sync pattern. A sync followed by any other character sends the receiver back to hunting, and nothing is delivered.
- R3: With `cfg_strip`=1, characters equal to the sync pattern are dropped. This applies after the opening pair and inside the data phase. The first non-sync character sets `rx_active` and is delivered.
- R4: With `cfg_strip`=0, the character right after the opening pair sets `rx_active` and is delivered, even when it equals the sync pattern.
- R5: `cfg_len` selects the character length: 0=5, 1=6, 2=7 and 3=8 bits. Only that many low bits of the pattern are compared. `rx_data` holds the character zero-extended, with its first received bit at bit 0.
- R6: A delivered character sets `data_avail`. A `rd_data` pulse clears `data_avail` on the next edge.
- R7: If a character completes while `data_avail` is set and no read is made in that cycle, the character is discarded and `rx_data` keeps its value. This sets overrun, which is `rx_stat[0]`.
- R8: `stat_avail` rises when `rx_stat[0]` or `rx_stat[1]` goes from 0 to 1. A `rd_stat` pulse clears `stat_avail`, `rx_stat[0]` and `rx_stat[1]`.
- R9: With `cfg_err`=2 (even) or 3 (odd), each frame carries one parity bit after the data bits. A mismatch sets `rx_stat[1]`. The character is still delivered, without its parity bit.
- R10: With `cfg_err`=1, `rx_stat[2]` shows whether the CRC-16 remainder is zero after the latest delivered character, and it changes only when the next character is delivered. The CRC-16 uses polynomial x^16+x^15+x^2+1, is preset to zero and takes bits LSB first. A change of this bit never raises `stat_avail`.
- R11: The CRC includes only delivered characters. With stripping on, it starts at the first non-sync character. With stripping off, it starts at the character after the opening pair.
- R12: While `rx_en` is low, the receiver ignores incoming bits. On the next edge, all outputs and the alignment, CRC and status state are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; low clears and holds the receiver |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial data bit |
| cfg_len | input | 2 | Character length code (5 + code bits) |
| cfg_sync | input | 8 | Sync pattern, low `cfg_len`-selected bits used |
| cfg_strip | input | 1 | Drop sync characters when high |
| cfg_err | input | 2 | 0 none, 1 CRC-16, 2 even parity, 3 odd parity |
| rd_data | input | 1 | Data register read strobe |
| rd_stat | input | 1 | Status register read strobe |
| rx_data | output | 8 | Last accepted character |
| data_avail | output | 1 | A character is waiting in `rx_data` |
| rx_stat | output | 3 | [0] overrun, [1] parity error, [2] CRC good |
| stat_avail | output | 1 | A new error bit has been raised |
| rx_active | output | 1 | Data path open |

## Verification
The hardest case to reach is the CRC start point. It depends on whether stripping was active while the extra sync characters were arriving. It can only be seen as the one-character `rx_stat[2]` pulse at the very end of a message. The stimulus sends three sync characters before the message, with stripping on. It then sends two syncs followed by a message that begins with a sync character, with stripping off. In both cases it appends a check value that the bench computes, so the pulse appears only if the accumulation started at the character R11 calls for. The bench also leaves a character unread while the next one completes, which drives the overrun path without a read on the same edge.

// File: rtl/bsync_rx_pkg.sv
package bsync_rx_pkg;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_SYNC2 = 2'd1,
    ST_ENTRY = 2'd2,
    ST_DATA  = 2'd3
  } hunt_state_e;

  typedef enum logic [1:0] {
    EM_NONE     = 2'd0,
    EM_CRC      = 2'd1,
    EM_PAR_EVEN = 2'd2,
    EM_PAR_ODD  = 2'd3
  } err_mode_e;

  localparam int unsigned MIN_CHAR = 5;
  localparam int unsigned STAT_W   = 3;

endpackage

// File: rtl/bsync_rx_framer.sv
module bsync_rx_framer
  import bsync_rx_pkg::*;
#(
  parameter int unsigned MAX_CHAR = 8,
  parameter int unsigned LEN_W    = 2,
  localparam int unsigned SR_W    = MAX_CHAR + 1,
  localparam int unsigned CNT_W   = $clog2(SR_W + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_en,
  input  logic                bit_vld,
  input  logic                bit_in,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic [MAX_CHAR-1:0] cfg_sync,
  input  logic                cfg_strip,
  input  logic                par_mode,
  output logic                chr_vld,
  output logic [MAX_CHAR-1:0] chr,
  output logic                chr_par,
  output logic [CNT_W-1:0]    char_len,
  output logic                rx_active
);

  hunt_state_e         st_q, st_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [SR_W-1:0]     sr_q, sr_d, win;
  logic [CNT_W-1:0]    frame_len, shift_amt;
  logic [MAX_CHAR-1:0] mask;
  logic                match, frame_end, strip_hit, deliver;

  // Character geometry from the length code and parity mode.
  always_comb begin
    char_len  = CNT_W'(MIN_CHAR) + CNT_W'(cfg_len);
    frame_len = char_len + CNT_W'(par_mode);
    shift_amt = CNT_W'(SR_W) - frame_len;
    mask      = {MAX_CHAR{1'b1}} >> (CNT_W'(MAX_CHAR) - char_len);
  end

  // The newest bit enters at the top; the frame sits in the top frame_len bits.
  always_comb begin
    sr_d      = bit_vld ? {bit_in, sr_q[SR_W-1:1]} : sr_q;
    win       = sr_d >> shift_amt;
    chr       = win[MAX_CHAR-1:0] & mask;
    chr_par   = win[char_len];
    match     = (chr == (cfg_sync & mask));
    frame_end = bit_vld && ((cnt_q + 1'b1) == frame_len);
    strip_hit = cfg_strip && match;
  end

  // Next-state logic: sliding hunt, aligned second sync, entry, data.
  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    deliver = 1'b0;
    if (bit_vld) begin
      unique case (st_q)
        ST_HUNT: begin
          if (cnt_q < frame_len) cnt_d = cnt_q + 1'b1;
          if ((cnt_d >= frame_len) && match) begin
            st_d  = ST_SYNC2;
            cnt_d = '0;
          end
        end
        ST_SYNC2: begin
          cnt_d = frame_end ? '0 : cnt_q + 1'b1;
          if (frame_end) begin
            if (match) begin
              st_d = ST_ENTRY;
            end else begin
              st_d  = ST_HUNT;
              cnt_d = frame_len;
            end
          end
        end
        ST_ENTRY: begin
          cnt_d = frame_end ? '0 : cnt_q + 1'b1;
          if (frame_end && !strip_hit) begin
            st_d    = ST_DATA;
            deliver = 1'b1;
          end
        end
        ST_DATA: begin
          cnt_d = frame_end ? '0 : cnt_q + 1'b1;
          if (frame_end && !strip_hit) deliver = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_HUNT;
      cnt_q <= '0;
      sr_q  <= '0;
    end else if (!rx_en) begin
      st_q  <= ST_HUNT;
      cnt_q <= '0;
      sr_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sr_q  <= sr_d;
    end
  end

  assign chr_vld   = rx_en && deliver;
  assign rx_active = (st_q == ST_DATA);

endmodule

// File: rtl/bsync_rx_check.sv
module bsync_rx_check
  import bsync_rx_pkg::*;
#(
  parameter int unsigned MAX_CHAR = 8,
  parameter int unsigned CRC_W    = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'hA001,
  localparam int unsigned CNT_W   = $clog2(MAX_CHAR + 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_en,
  input  logic                chr_vld,
  input  logic [MAX_CHAR-1:0] chr,
  input  logic                chr_par,
  input  logic [CNT_W-1:0]    char_len,
  input  err_mode_e           err_mode,
  output logic                crc_good,
  output logic                par_fail
);

  logic [CRC_W-1:0] crc_q, crc_d, crc_next;
  logic             good_q, good_d;

  // Reflected shift of one character's data bits, LSB first.
  function automatic logic [CRC_W-1:0] crc_update(
    input logic [CRC_W-1:0]    c_in,
    input logic [MAX_CHAR-1:0] d,
    input logic [CNT_W-1:0]    n
  );
    logic [CRC_W-1:0] c;
    logic             fb;
    c = c_in;
    for (int i = 0; i < MAX_CHAR; i++) begin
      if (CNT_W'(i) < n) begin
        fb = c[0] ^ d[i];
        c  = c >> 1;
        if (fb) c = c ^ CRC_POLY;
      end
    end
    return c;
  endfunction

  always_comb begin
    crc_next = crc_update(crc_q, chr, char_len);
    crc_d    = crc_q;
    good_d   = good_q;
    if (chr_vld && (err_mode == EM_CRC)) begin
      crc_d  = crc_next;
      good_d = (crc_next == '0);
    end
  end

  // Parity modes: odd expects an odd count over data plus parity bit.
  assign par_fail = chr_vld && err_mode[1] && (((^chr) ^ chr_par) != err_mode[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= '0;
      good_q <= 1'b0;
    end else if (!rx_en) begin
      crc_q  <= '0;
      good_q <= 1'b0;
    end else begin
      crc_q  <= crc_d;
      good_q <= good_d;
    end
  end

  assign crc_good = good_q;

endmodule

// File: rtl/bsync_rx_regs.sv
module bsync_rx_regs #(
  parameter int unsigned MAX_CHAR = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_en,
  input  logic                chr_vld,
  input  logic [MAX_CHAR-1:0] chr,
  input  logic                par_fail,
  input  logic                rd_data,
  input  logic                rd_stat,
  output logic [MAX_CHAR-1:0] rx_data,
  output logic                data_avail,
  output logic                ovr_flag,
  output logic                par_flag,
  output logic                stat_avail
);

  logic [MAX_CHAR-1:0] data_q, data_d;
  logic avail_q, avail_d, ovr_q, ovr_d, perr_q, perr_d, savail_q, savail_d;
  logic avail_left, ovr_base, perr_base, sav_base, ovr_set, perr_set, rise;

  always_comb begin
    avail_left = avail_q && !rd_data;
    ovr_base   = ovr_q && !rd_stat;
    perr_base  = perr_q && !rd_stat;
    sav_base   = savail_q && !rd_stat;
    ovr_set    = chr_vld && avail_left;
    perr_set   = chr_vld && par_fail;
    rise       = (ovr_set && !ovr_base) || (perr_set && !perr_base);

    data_d   = data_q;
    avail_d  = avail_left;
    if (chr_vld && !avail_left) begin
      data_d  = chr;
      avail_d = 1'b1;
    end
    ovr_d    = ovr_base || ovr_set;
    perr_d   = perr_base || perr_set;
    savail_d = sav_base || rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      avail_q  <= 1'b0;
      ovr_q    <= 1'b0;
      perr_q   <= 1'b0;
      savail_q <= 1'b0;
    end else if (!rx_en) begin
      data_q   <= '0;
      avail_q  <= 1'b0;
      ovr_q    <= 1'b0;
      perr_q   <= 1'b0;
      savail_q <= 1'b0;
    end else begin
      data_q   <= data_d;
      avail_q  <= avail_d;
      ovr_q    <= ovr_d;
      perr_q   <= perr_d;
      savail_q <= savail_d;
    end
  end

  assign rx_data    = data_q;
  assign data_avail = avail_q;
  assign ovr_flag   = ovr_q;
  assign par_flag   = perr_q;
  assign stat_avail = savail_q;

endmodule

// File: rtl/bsync_rx.sv
module bsync_rx
  import bsync_rx_pkg::*;
#(
  parameter int unsigned MAX_CHAR = 8,
  parameter int unsigned LEN_W    = 2,
  parameter int unsigned CRC_W    = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'hA001,
  parameter int unsigned RST_STAGES = 2,
  localparam int unsigned CNT_W   = $clog2(MAX_CHAR + 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_en,
  input  logic                bit_vld,
  input  logic                bit_in,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic [MAX_CHAR-1:0] cfg_sync,
  input  logic                cfg_strip,
  input  logic [1:0]          cfg_err,
  input  logic                rd_data,
  input  logic                rd_stat,
  output logic [MAX_CHAR-1:0] rx_data,
  output logic                data_avail,
  output logic [STAT_W-1:0]   rx_stat,
  output logic                stat_avail,
  output logic                rx_active
);

  // Reset: asserted asynchronously, released after RST_STAGES edges.
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_n_s = rst_pipe[RST_STAGES-1];

  err_mode_e           err_mode;
  logic                chr_vld, chr_par, crc_good, par_fail, ovr_flag, par_flag;
  logic [MAX_CHAR-1:0] chr;
  logic [CNT_W-1:0]    char_len;

  assign err_mode = err_mode_e'(cfg_err);

  bsync_rx_framer #(.MAX_CHAR(MAX_CHAR), .LEN_W(LEN_W)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .rx_en     (rx_en),
    .bit_vld   (bit_vld),
    .bit_in    (bit_in),
    .cfg_len   (cfg_len),
    .cfg_sync  (cfg_sync),
    .cfg_strip (cfg_strip),
    .par_mode  (cfg_err[1]),
    .chr_vld   (chr_vld),
    .chr       (chr),
    .chr_par   (chr_par),
    .char_len  (char_len),
    .rx_active (rx_active)
  );

  bsync_rx_check #(.MAX_CHAR(MAX_CHAR), .CRC_W(CRC_W), .CRC_POLY(CRC_POLY)) u_check (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .rx_en    (rx_en),
    .chr_vld  (chr_vld),
    .chr      (chr),
    .chr_par  (chr_par),
    .char_len (char_len),
    .err_mode (err_mode),
    .crc_good (crc_good),
    .par_fail (par_fail)
  );

  bsync_rx_regs #(.MAX_CHAR(MAX_CHAR)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .rx_en      (rx_en),
    .chr_vld    (chr_vld),
    .chr        (chr),
    .par_fail   (par_fail),
    .rd_data    (rd_data),
    .rd_stat    (rd_stat),
    .rx_data    (rx_data),
    .data_avail (data_avail),
    .ovr_flag   (ovr_flag),
    .par_flag   (par_flag),
    .stat_avail (stat_avail)
  );

  assign rx_stat = {crc_good, par_flag, ovr_flag};

endmodule

// File: rtl/bsync_rx_sva.sv
module bsync_rx_sva #(
  parameter int unsigned MAX_CHAR = 8,
  parameter int unsigned LEN_W    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rx_en,
  input logic                bit_vld,
  input logic                bit_in,
  input logic [LEN_W-1:0]    cfg_len,
  input logic [MAX_CHAR-1:0] cfg_sync,
  input logic                cfg_strip,
  input logic [1:0]          cfg_err,
  input logic                rd_data,
  input logic                rd_stat,
  input logic [MAX_CHAR-1:0] rx_data,
  input logic                data_avail,
  input logic [2:0]          rx_stat,
  input logic                stat_avail,
  input logic                rx_active
);

  // R3: a character is only presented once the data path is open
  a_r3_avail_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_avail) |-> rx_active);

  // R6: a read with no bit arriving leaves no character pending
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !bit_vld && rx_en) |=> !data_avail);

  // R7: when overrun is raised the held character is untouched
  a_r7_overrun_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_stat[0]) |-> $stable(rx_data));

  // R8: the status strobe rises only with an error bit
  a_r8_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_avail) |-> ($rose(rx_stat[0]) || $rose(rx_stat[1])));

  // R10: a CRC-good change alone never raises the status strobe
  a_r10_crc_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(rx_stat[2]) && !$rose(rx_stat[0]) && !$rose(rx_stat[1])) |-> !$rose(stat_avail));

  // R12: disabling clears everything on the next edge
  a_r12_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!data_avail && !stat_avail && !rx_active && (rx_stat == 3'b000)));

endmodule

bind bsync_rx bsync_rx_sva #(.MAX_CHAR(MAX_CHAR), .LEN_W(LEN_W)) u_sva (.*);

// File: tb/sim_bsync_rx.sv
module sim_bsync_rx;

  logic       clk;
  logic       rst_n, rx_en, bit_vld, bit_in, cfg_strip, rd_data, rd_stat;
  logic [1:0] cfg_len, cfg_err;
  logic [7:0] cfg_sync, rx_data;
  logic [2:0] rx_stat;
  logic       data_avail, stat_avail, rx_active;

  int checks = 0;
  int errors = 0;

  localparam logic [7:0] SYN = 8'h16;

  bsync_rx u0 (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .bit_vld(bit_vld), .bit_in(bit_in),
    .cfg_len(cfg_len), .cfg_sync(cfg_sync), .cfg_strip(cfg_strip), .cfg_err(cfg_err),
    .rd_data(rd_data), .rd_stat(rd_stat), .rx_data(rx_data), .data_avail(data_avail),
    .rx_stat(rx_stat), .stat_avail(stat_avail), .rx_active(rx_active)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_bits(input logic [8:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_vld = 1'b1; bit_in = v[i];
      @(negedge clk); bit_vld = 1'b0;
    end
  endtask

  task automatic rd_dat();
    @(negedge clk); rd_data = 1'b1;
    @(negedge clk); rd_data = 1'b0;
  endtask

  task automatic rd_st();
    @(negedge clk); rd_stat = 1'b1;
    @(negedge clk); rd_stat = 1'b0;
  endtask

  task automatic send_rd(input logic [7:0] v);
    send_bits({1'b0, v}, 8);
    rd_dat();
  endtask

  task automatic restart(input logic [1:0] len, input logic strip, input logic [1:0] em);
    @(negedge clk); rx_en = 1'b0;
    cfg_len = len; cfg_strip = strip; cfg_err = em;
    @(negedge clk); rx_en = 1'b1;
  endtask

  // Reference CRC-16, reflected polynomial, zero preset, LSB first.
  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 16'hA001;
      else             r = r >> 1;
    end
    return r;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "avail in reset", int'(data_avail), 0);
    chk("R1", "active in reset", int'(rx_active), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "status after reset", int'({stat_avail, rx_stat}), 0);
    chk("R1", "data after reset", int'(rx_data), 0);
  endtask

  task automatic t_strip_entry();
    restart(2'd3, 1'b1, 2'd0);
    send_bits(9'b111, 3);
    send_bits({1'b0, SYN}, 8);
    chk("R2", "active after one sync", int'(rx_active), 0);
    send_bits({1'b0, SYN}, 8);
    chk("R2", "active after two syncs", int'(rx_active), 0);
    send_bits({1'b0, SYN}, 8);
    chk("R3", "extra sync stripped", int'(data_avail), 0);
    send_bits(9'h041, 8);
    chk("R3", "active on first data", int'(rx_active), 1);
    chk("R6", "avail on delivery", int'(data_avail), 1);
    chk("R5", "first data value", int'(rx_data), 'h41);
    rd_dat();
    chk("R6", "avail after read", int'(data_avail), 0);
    send_bits({1'b0, SYN}, 8);
    chk("R3", "in-data sync stripped", int'(data_avail), 0);
    send_bits(9'h022, 8);
    chk("R3", "data after stripped sync", int'(rx_data), 'h22);
    rd_dat();
  endtask

  task automatic t_single_sync();
    restart(2'd3, 1'b1, 2'd0);
    send_bits({1'b0, SYN}, 8);
    send_bits(9'h041, 8);
    send_bits(9'h041, 8);
    chk("R2", "single sync no entry", int'(rx_active), 0);
    chk("R2", "single sync no data", int'(data_avail), 0);
  endtask

  task automatic t_nostrip();
    restart(2'd3, 1'b0, 2'd0);
    send_bits({1'b0, SYN}, 8);
    send_bits({1'b0, SYN}, 8);
    send_bits({1'b0, SYN}, 8);
    chk("R4", "third sync delivered", int'(data_avail), 1);
    chk("R4", "third sync value", int'(rx_data), int'(SYN));
    chk("R4", "active without strip", int'(rx_active), 1);
    rd_dat();
  endtask

  task automatic t_len5();
    restart(2'd0, 1'b1, 2'd0);
    send_bits(9'h016, 5);
    send_bits(9'h016, 5);
    send_bits(9'h00B, 5);
    chk("R5", "5-bit char value", int'(rx_data), 'h0B);
    chk("R5", "5-bit char avail", int'(data_avail), 1);
    rd_dat();
  endtask

  task automatic t_overrun();
    restart(2'd3, 1'b1, 2'd0);
    send_bits({1'b0, SYN}, 8);
    send_bits({1'b0, SYN}, 8);
    send_bits(9'h05A, 8);
    chk("R8", "no strobe before error", int'(stat_avail), 0);
    send_bits(9'h033, 8);
    chk("R7", "overrun bit", int'(rx_stat[0]), 1);
    chk("R7", "held data kept", int'(rx_data), 'h5A);
    chk("R8", "strobe on overrun", int'(stat_avail), 1);
    rd_st();
    chk("R8", "overrun cleared by read", int'(rx_stat[0]), 0);
    chk("R8", "strobe cleared by read", int'(stat_avail), 0);
    rd_dat();
  endtask

  task automatic t_parity();
    restart(2'd2, 1'b1, 2'd2);
    send_bits(9'h016, 8);
    send_bits(9'h016, 8);
    send_bits(9'h035, 8);
    chk("R9", "good even parity", int'(rx_stat[1]), 0);
    chk("R9", "parity stripped", int'(rx_data), 'h35);
    rd_dat();
    send_bits(9'h0B5, 8);
    chk("R9", "bad even parity", int'(rx_stat[1]), 1);
    chk("R9", "strobe on parity", int'(stat_avail), 1);
    chk("R9", "data after bad parity", int'(rx_data), 'h35);
    rd_st(); rd_dat();
    restart(2'd2, 1'b1, 2'd3);
    send_bits(9'h016, 8);
    send_bits(9'h016, 8);
    send_bits(9'h0B5, 8);
    chk("R9", "good odd parity", int'(rx_stat[1]), 0);
    chk("R9", "odd data", int'(rx_data), 'h35);
    rd_dat();
  endtask

  task automatic t_crc();
    logic [15:0] c;
    restart(2'd3, 1'b1, 2'd1);
    send_bits({1'b0, SYN}, 8);
    send_bits({1'b0, SYN}, 8);
    send_bits({1'b0, SYN}, 8);
    c = ref_crc(ref_crc(16'h0, 8'h12), 8'h34);
    send_rd(8'h12);
    send_rd(8'h34);
    send_rd(c[7:0]);
    send_bits({1'b0, c[15:8]}, 8);
    chk("R11", "crc good, strip on", int'(rx_stat[2]), 1);
    chk("R10", "crc good no strobe", int'(stat_avail), 0);
    rd_dat();
    send_bits(9'h055, 8);
    chk("R10", "crc good one char", int'(rx_stat[2]), 0);
    rd_dat();
    restart(2'd3, 1'b0, 2'd1);
    send_bits({1'b0, SYN}, 8);
    send_bits({1'b0, SYN}, 8);
    c = ref_crc(ref_crc(16'h0, SYN), 8'h31);
    send_rd(SYN);
    send_rd(8'h31);
    send_rd(c[7:0]);
    send_bits({1'b0, c[15:8]}, 8);
    chk("R11", "crc good, strip off", int'(rx_stat[2]), 1);
    rd_dat();
  endtask

  task automatic t_disable();
    restart(2'd3, 1'b1, 2'd0);
    send_bits({1'b0, SYN}, 8);
    send_bits({1'b0, SYN}, 8);
    send_bits(9'h041, 8);
    send_bits(9'h042, 8);
    @(negedge clk); rx_en = 1'b0;
    @(negedge clk);
    chk("R12", "disable clears avail", int'(data_avail), 0);
    chk("R12", "disable clears status", int'({stat_avail, rx_stat}), 0);
    chk("R12", "disable clears active", int'(rx_active), 0);
    send_bits({1'b0, SYN}, 8);
    send_bits({1'b0, SYN}, 8);
    send_bits(9'h041, 8);
    chk("R12", "bits ignored while off", int'({rx_active, data_avail}), 0);
    rx_en = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; rx_en = 1'b1; bit_vld = 1'b0; bit_in = 1'b0;
    cfg_len = 2'd3; cfg_sync = SYN; cfg_strip = 1'b1; cfg_err = 2'd0;
    rd_data = 1'b0; rd_stat = 1'b0;
    t_reset();
    t_strip_entry();
    t_single_sync();
    t_nostrip();
    t_len5();
    t_overrun();
    t_parity();
    t_crc();
    t_disable();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule